// File: doc/BRIEF.md
# Single-Frame Receive Byte Buffer

This block sits between a radio receive MAC and a host register port and holds exactly one received frame. The MAC pushes the frame as a byte stream. The first byte is the frame length. The payload follows, and its first byte is the low byte of the frame-control field. A link-quality byte and then a signal-strength byte close the stream. The block writes these bytes one after another into a 128-byte store through an internal write pointer. The host reads the store by byte address and uses a small register set for control, interrupt enables and interrupt status.

A frame is taken only when the buffer is free and reception is enabled, and only from its first byte. Once a frame is complete the buffer is full. It stays full until the host reads offset 0, which is the length byte. That read returns the pointer to zero and frees the buffer for the next frame. A self-clearing flush bit and a self-clearing soft-reset bit also free the buffer. Two interrupt flags, receive-done and security-enabled, are gated by their own enables onto one interrupt line.

The MAC stream never sees back-pressure. `in_ready` is always 1 and every beat with `in_valid` high is consumed in that cycle. Bytes that cannot be stored are dropped, and the stream is never stalled. Host reads return data in the cycle after `host_rd`, with `host_rvalid` high for that one cycle.

Top module: `rxframe_buf`

## Requirements
- R1: After reset `irq` is 0, `in_ready` is 1, the buffer is free, and the control register (host address 0x000) and the status register (0x002) both read 0.
- R2: For an accepted frame of length L, the stream bytes land at offsets 0..L+2 in order: the length at 0, the payload at 1..L, link quality at L+1 and signal strength at L+2. Host address 0x100+k reads offset k.
- R3: The cycle after the last byte of an accepted frame is written, status bit 0 (receive done) is 1 and the buffer is full.
- R4: At frame completion, status bit 1 (security) is set when bit 3 of the byte at offset 1 is 1. It stays 0 when that bit is 0.
- R5: While the buffer is full, an arriving frame is dropped: the stored bytes and the status bits are unchanged.
- R6: A host read of offset 0 while full frees the buffer, and the next frame is stored from offset 0.
- R7: Writing 1 to control bit 0 (flush) frees the buffer and returns the pointer to 0. The bit reads back as 0 afterwards.
- R8: Writing 1 to control bit 1 (soft reset) frees the buffer and clears both status bits. The bit reads back as 0 afterwards.
- R9: While control bit 2 (receive off) is 1, frames that start are dropped. Writing it back to 0 lets the next frame be stored.
- R10: A host read of the status register returns the flags and clears them. A flag set in the same cycle as the read is returned as 0 by that read and stays set.
- R11: `irq` is the OR over the flags of each flag ANDed with its enable bit. The enable register is at address 0x001, with bit 0 for receive done and bit 1 for security.
- R12: A frame whose first byte arrived while the buffer was not accepting is dropped entirely, even if the buffer becomes free part-way through that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | MAC byte valid |
| in_ready | output | 1 | Always 1; every valid beat is consumed |
| in_data | input | 8 | MAC byte |
| in_last | input | 1 | Marks the final byte (signal strength) of a frame |
| host_addr | input | 9 | Bit 8 = 1 selects the buffer at offset [6:0]; otherwise a register index |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe (registers only) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid the cycle after `host_rd` |
| host_rvalid | output | 1 | High for the one cycle in which `host_rdata` is valid |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach depend on timing between the two sides. One is a status read that lands in the exact cycle in which a frame's last byte completes. The other is a host read of offset 0 that frees the buffer part-way through a frame that was already being dropped. The bench forks the MAC stream task against a host read task that is delayed by a counted number of falling edges, so that the read strobe and the chosen stream byte are sampled on the same rising edge. It then checks the stored bytes and the flags through the host port.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  typedef enum logic [1:0] {
    RB_FREE = 2'd0,
    RB_FILL = 2'd1,
    RB_FULL = 2'd2
  } rb_state_e;

  // register indices (host_addr MSB = 0)
  localparam int REG_CTRL = 0;
  localparam int REG_IEN  = 1;
  localparam int REG_STAT = 2;

  // control bit positions
  localparam int CTL_FLUSH = 0;
  localparam int CTL_SRST  = 1;
  localparam int CTL_RXOFF = 2;

  // interrupt flag positions
  localparam int NFLAG   = 2;
  localparam int FLG_RX  = 0;
  localparam int FLG_SEC = 1;

  // security-enable bit inside frame-control low byte
  localparam int SEC_BIT = 3;
endpackage

// File: rtl/rxbuf_mem.sv
module rxbuf_mem #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // combinational read; the top registers the host result
  assign rdata = store[raddr];
endmodule

// File: rtl/rxbuf_wrctl.sv
module rxbuf_wrctl
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          in_sec_bit,
  input  logic          rx_off,
  input  logic          rearm_rd,
  input  logic          flush,
  input  logic          srst,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output rb_state_e     state,
  output logic [PW-1:0] wr_ptr,
  output logic          frame_done,
  output logic          frame_sec
);
  rb_state_e     st_q;
  logic [PW-1:0] ptr_q;
  logic          mid_q;   // stream is inside a frame
  logic          sec_q;
  logic          first_beat, accept, abort, room;

  assign abort      = flush | srst;
  assign first_beat = in_valid & ~mid_q;
  assign room       = ~ptr_q[AW];
  assign accept     = ~abort &
                      (((st_q == RB_FREE) & first_beat & ~rx_off) |
                       ((st_q == RB_FILL) & in_valid));

  assign mem_we     = accept & room;
  assign mem_waddr  = ptr_q[AW-1:0];
  assign frame_done = accept & in_last;

  always_comb begin
    if (ptr_q == '0)               frame_sec = 1'b0;
    else if (ptr_q == PW'(1))      frame_sec = in_sec_bit;
    else                           frame_sec = sec_q;
  end

  // framing tracker on the wire, independent of acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mid_q <= 1'b0;
    else if (in_valid) mid_q <= ~in_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RB_FREE;
      ptr_q <= '0;
      sec_q <= 1'b0;
    end else if (abort) begin
      st_q  <= RB_FREE;
      ptr_q <= '0;
    end else begin
      unique case (st_q)
        RB_FREE: begin
          if (accept) begin
            ptr_q <= PW'(1);
            sec_q <= 1'b0;
            st_q  <= in_last ? RB_FULL : RB_FILL;
          end
        end
        RB_FILL: begin
          if (accept) begin
            if (room) ptr_q <= ptr_q + PW'(1);
            if (ptr_q == PW'(1)) sec_q <= in_sec_bit;
            if (in_last) st_q <= RB_FULL;
          end
        end
        RB_FULL: begin
          if (rearm_rd) begin
            st_q  <= RB_FREE;
            ptr_q <= '0;
          end
        end
        default: st_q <= RB_FREE;
      endcase
    end
  end

  assign state  = st_q;
  assign wr_ptr = ptr_q;
endmodule

// File: rtl/rxbuf_irq.sv
module rxbuf_irq
  import rxbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             stat_rd,
  input  logic [NFLAG-1:0] set,
  input  logic [NFLAG-1:0] enable,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      f_q <= 1'b0;
      else if (srst)   f_q <= 1'b0;
      else if (set[g]) f_q <= 1'b1;   // new event beats read-clear
      else if (stat_rd) f_q <= 1'b0;
    end
    assign flags[g] = f_q;
  end

  assign irq = |(flags & enable);
endmodule

// File: rtl/rxframe_buf.sv
module rxframe_buf
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int HAW   = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  input  logic           in_last,
  input  logic [HAW-1:0] host_addr,
  input  logic           host_rd,
  input  logic           host_wr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           host_rvalid,
  output logic           irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int RW = HAW - 1;

  logic             sel_buf, sel_ctrl, sel_ien, sel_stat;
  logic             flush_q, srst_q, rxoff_q;
  logic [NFLAG-1:0] ien_q, flags;
  logic             stat_rd, rearm_rd;
  logic             mem_we, frame_done, frame_sec, rx_flag;
  logic [AW-1:0]    mem_waddr;
  logic [DW-1:0]    mem_rdata, rd_mux;
  logic [PW-1:0]    wr_ptr;
  rb_state_e        st_q;
  logic             unused_wbits;

  assign in_ready = 1'b1;

  assign sel_buf  = host_addr[HAW-1];
  assign sel_ctrl = ~sel_buf & (host_addr[RW-1:0] == RW'(REG_CTRL));
  assign sel_ien  = ~sel_buf & (host_addr[RW-1:0] == RW'(REG_IEN));
  assign sel_stat = ~sel_buf & (host_addr[RW-1:0] == RW'(REG_STAT));

  assign stat_rd  = host_rd & sel_stat;
  assign rearm_rd = host_rd & sel_buf & (host_addr[RW-1:0] == '0);
  assign unused_wbits = ^host_wdata[DW-1:CTL_RXOFF+1];

  // control and enable registers; flush and soft reset self-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      srst_q  <= 1'b0;
      rxoff_q <= 1'b0;
      ien_q   <= '0;
    end else begin
      flush_q <= 1'b0;
      srst_q  <= 1'b0;
      if (host_wr && sel_ctrl) begin
        flush_q <= host_wdata[CTL_FLUSH];
        srst_q  <= host_wdata[CTL_SRST];
        rxoff_q <= host_wdata[CTL_RXOFF];
      end
      if (host_wr && sel_ien) ien_q <= host_wdata[NFLAG-1:0];
    end
  end

  rxbuf_mem #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (in_data),
    .raddr (host_addr[AW-1:0]),
    .rdata (mem_rdata)
  );

  rxbuf_wrctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_sec_bit (in_data[SEC_BIT]),
    .rx_off     (rxoff_q),
    .rearm_rd   (rearm_rd),
    .flush      (flush_q),
    .srst       (srst_q),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .state      (st_q),
    .wr_ptr     (wr_ptr),
    .frame_done (frame_done),
    .frame_sec  (frame_sec)
  );

  rxbuf_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst_q),
    .stat_rd (stat_rd),
    .set     ({frame_done & frame_sec, frame_done}),
    .enable  (ien_q),
    .flags   (flags),
    .irq     (irq)
  );

  assign rx_flag = flags[FLG_RX];

  always_comb begin
    if (sel_buf)       rd_mux = mem_rdata;
    else if (sel_ctrl) rd_mux = DW'({rxoff_q, srst_q, flush_q});
    else if (sel_ien)  rd_mux = DW'(ien_q);
    else if (sel_stat) rd_mux = DW'(flags);
    else               rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) host_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/rxbuf_checker.sv
module rxbuf_checker
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int PW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input rb_state_e     st_q,
  input logic [PW-1:0] wr_ptr,
  input logic          mem_we,
  input logic          rx_flag,
  input logic          frame_done,
  input logic          flush_q,
  input logic          srst_q,
  input logic          rxoff_q,
  input logic          stat_rd
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq && st_q == RB_FREE));

  assert_ptr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= PW'(DEPTH));

  assert_done_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_flag);

  assert_full_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RB_FULL) |-> !mem_we);

  assert_flush_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> (st_q == RB_FREE && wr_ptr == '0));

  assert_srst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!rx_flag && st_q == RB_FREE));

  assert_rxoff_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RB_FREE && rxoff_q) |=> (st_q == RB_FREE));

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !frame_done && !srst_q) |=> !rx_flag);
endmodule

bind rxframe_buf rxbuf_checker #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq        (irq),
  .st_q       (st_q),
  .wr_ptr     (wr_ptr),
  .mem_we     (mem_we),
  .rx_flag    (rx_flag),
  .frame_done (frame_done),
  .flush_q    (flush_q),
  .srst_q     (srst_q),
  .rxoff_q    (rxoff_q),
  .stat_rd    (stat_rd)
);

// File: tb/tb_rxframe_buf.sv
module tb_rxframe_buf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic [8:0] host_addr = '0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_rvalid;
  logic       irq;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  logic [7:0] fbuf [0:63];
  int         fn;
  logic [7:0] img  [0:63];
  int         imgn;

  always #10 clk = ~clk;   // 50 MHz

  rxframe_buf dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .host_addr(host_addr),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic build(input int len, input logic [7:0] fc, input logic [7:0] seed);
    fbuf[0] = 8'(len);
    fbuf[1] = fc;
    for (int i = 2; i <= len; i++) fbuf[i] = seed + 8'(i * 7);
    fbuf[len+1] = seed ^ 8'hA5;
    fbuf[len+2] = seed ^ 8'h3C;
    fn = len + 3;
  endtask

  task automatic keep_image();
    for (int i = 0; i < fn; i++) img[i] = fbuf[i];
    imgn = fn;
  endtask

  task automatic send();
    for (int i = 0; i < fn; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fbuf[i];
      in_last  = (i == fn - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic hread(input logic [8:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    host_rd   = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic hwrite(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr  = a;
    host_wdata = d;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  // compare stored offsets 1..imgn-1 (offset 0 left unread)
  task automatic check_image(input string req);
    logic [7:0] d;
    for (int i = 1; i < imgn; i++) begin
      hread(9'h100 + 9'(i), d);
      chk(req, d, img[i]);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", irq, 0);
    chk("R1 in_ready", in_ready, 1);
    hread(9'h002, d); chk("R1 status", d, 0);
    hread(9'h000, d); chk("R1 control", d, 0);
  endtask

  task automatic t_store();
    logic [7:0] d;
    hwrite(9'h001, 8'h03);
    build(5, 8'h41, 8'h10); keep_image(); send();
    chk("R3 irq after frame", irq, 1);
    check_image("R2 stored byte");
    hread(9'h002, d); chk("R3/R4 status rx only", d, 8'h01);
    chk("R11 irq after clear", irq, 0);
    hread(9'h002, d); chk("R10 status cleared", d, 0);
  endtask

  task automatic t_full_ignore();
    logic [7:0] d;
    build(4, 8'hFF, 8'h77); send();
    hread(9'h002, d); chk("R5 no new flag", d, 0);
    check_image("R5 contents kept");
  endtask

  task automatic t_rearm();
    logic [7:0] d;
    hread(9'h100, d); chk("R6 length byte", d, img[0]);
    build(3, 8'h49, 8'h20); keep_image(); send();
    hread(9'h100, d); chk("R6 new length at offset 0", d, 3);
    check_image("R2 second frame");
    hread(9'h002, d); chk("R4 security flag", d, 8'h03);
  endtask

  task automatic t_ien();
    logic [7:0] d;
    hwrite(9'h001, 8'h02);
    build(4, 8'h01, 8'h30); keep_image(); send();
    chk("R11 masked irq", irq, 0);
    hread(9'h002, d); chk("R11 flag without irq", d, 8'h01);
    hwrite(9'h001, 8'h03);
  endtask

  task automatic t_flush();
    logic [7:0] d;
    hwrite(9'h000, 8'h01);
    repeat (2) @(negedge clk);
    hread(9'h000, d); chk("R7 flush self-clears", d, 0);
    build(6, 8'h08, 8'h40); keep_image(); send();
    hread(9'h100, d); chk("R7 pointer back at 0", d, 6);
    check_image("R7 frame after flush");
    chk("R7 irq", irq, 1);
  endtask

  task automatic t_srst();
    logic [7:0] d;
    hwrite(9'h000, 8'h02);
    repeat (2) @(negedge clk);
    chk("R8 irq cleared", irq, 0);
    hread(9'h002, d); chk("R8 flags cleared", d, 0);
    hread(9'h000, d); chk("R8 bit self-clears", d, 0);
    build(2, 8'h00, 8'h50); keep_image(); send();
    check_image("R8 frame after soft reset");
    hread(9'h002, d); chk("R8 rx after soft reset", d, 8'h01);
  endtask

  task automatic t_rxoff();
    logic [7:0] d;
    hread(9'h100, d);
    hwrite(9'h000, 8'h04);
    build(3, 8'h08, 8'h60); send();
    hread(9'h002, d); chk("R9 off: no flag", d, 0);
    hread(9'h101, d); chk("R9 off: contents kept", d, img[1]);
    hwrite(9'h000, 8'h00);
    build(3, 8'h02, 8'h70); keep_image(); send();
    hread(9'h002, d); chk("R9 re-enabled flag", d, 8'h01);
    check_image("R9 re-enabled frame");
  endtask

  task automatic t_tail();
    logic [7:0] d;
    build(6, 8'h08, 8'h80);
    fork
      send();
      begin
        repeat (3) @(negedge clk);
        hread(9'h100, d);
      end
    join
    chk("R6 rearm read length", d, img[0]);
    hread(9'h002, d); chk("R12 tail frame no flag", d, 0);
    hread(9'h101, d); chk("R12 tail not stored", d, img[1]);
    build(5, 8'h00, 8'h90); keep_image(); send();
    hread(9'h002, d); chk("R12 next frame taken", d, 8'h01);
    check_image("R12 next frame bytes");
  endtask

  task automatic t_race();
    logic [7:0] d;
    hread(9'h100, d);
    build(3, 8'h00, 8'hA0); keep_image();
    fork
      send();
      begin
        repeat (5) @(negedge clk);
        hread(9'h002, d);
      end
    join
    chk("R10 same-cycle read returns old", d, 0);
    hread(9'h002, d); chk("R10 same-cycle set kept", d, 8'h01);
    check_image("R2 race frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store();
    t_full_ignore();
    t_rearm();
    t_ien();
    t_flush();
    t_srst();
    t_rxoff();
    t_tail();
    t_race();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end
endmodule